// File: doc/BRIEF.md
# Serial-Bus Byte-Access Configuration Target

This block is a two-wire serial-bus target that holds a small configuration register file. A bus controller writes or reads one register per transaction. Each transaction carries a command code: when its most significant bit is one, the access is a single-byte access, and the lower seven bits select the register offset. There are two registers.

- Offset 0 holds a drive-strength select bit. Its five low bits show strap pins, which are captured once after reset and cannot be written.
- Offset 1 holds three enables, one for each of three differential output pairs.

SCL and SDA pass through a synchronizer and a glitch filter. Start and stop are then found as SDA edges while SCL is high. The engine state machine has nine states, and it changes state only on filtered SCL edges or on bus conditions.

- `ST_IDLE` waits for a start.
- `ST_ADDR` shifts in the address byte. When the byte ends, a matching address leads to `ST_ADDR_ACK` and any other address leads to `ST_IDLE`.
- `ST_ADDR_ACK` drives the acknowledge. On the falling SCL edge it goes to `ST_CMD` when R/W is 0, or to `ST_RDATA` when R/W is 1.
- `ST_CMD` shifts in the command. When the byte ends it goes to `ST_CMD_ACK` if bit 7 is one, or to `ST_IDLE` if bit 7 is zero.
- `ST_CMD_ACK` goes to `ST_WDATA`. `ST_WDATA` shifts in the data byte and goes to `ST_WDATA_ACK`, which then goes to `ST_IDLE`.
- `ST_RDATA` shifts out the register byte and goes to `ST_RD_ACK`. `ST_RD_ACK` samples the controller's answer on the rising SCL edge and goes to `ST_IDLE`.
- A stop moves every state to `ST_IDLE`. A start, including a repeated start, moves every state to `ST_ADDR`.

Top module: `cfg_byte_slave`

## Requirements
- R1: After reset, `drv_high` is 1, `pair_en` is 3'b111 and `sda_oe` is 0. Offset 0 reads as {1'b0, 1'b1, 1'b0, strap[4:0]} and offset 1 reads 8'h7F.
- R2: The target acknowledges an address byte by holding SDA low during the ninth clock, but only when the upper seven bits equal `TGT_ADDR`. On any other address it does not acknowledge, and it ignores the bus until the next start.
- R3: A byte write works as follows. The controller sends start, the address with R/W=0, a command with bit 7 set and one data byte, then stop. All three bytes are acknowledged, and the data lands in the register at offset command[6:0].
- R4: A byte read works as follows. The controller sends start, the address with R/W=0 and the command, then a repeated start and the address with R/W=1. The target then drives the register byte MSB first, and the controller's NACK and stop end the transaction.
- R5: A command byte with bit 7 clear is not acknowledged. The data byte that follows is not acknowledged either, and no register changes.
- R6: Offset 0 bit 6 drives `drv_high`: 1 selects high drive and 0 selects low drive. Bits 7 and 5 always read 0 and ignore writes.
- R7: Offset 1 bit n drives `pair_en[n]` for n from 0 to 2: 1 enables the pair and 0 puts it in high impedance. Bits 6:3 always read 1, bit 7 always reads 0, and these upper bits ignore writes.
- R8: Offset 0 bits 4:0 return the `strap_fs` value sampled on the first clock after reset. Later changes on `strap_fs`, and writes to these bits, have no effect.
- R9: Reads at offsets 2 to 127 return 8'h00. Writes to those offsets are acknowledged, but they change no register and no output.
- R10: A pulse on SCL or SDA that is shorter than `FILT_LEN` system clocks is ignored. It creates no extra bit and no bus condition.
- R11: SDA is only ever pulled low, through `sda_oe`. `sda_oe` is never high in `ST_IDLE`, and it changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, sampled |
| sda_i | input | 1 | Serial data line, sampled |
| sda_oe | output | 1 | When 1, pull SDA low |
| strap_fs | input | 5 | Frequency-select strap pins |
| drv_high | output | 1 | Drive-strength select, 1 = high drive |
| pair_en | output | 3 | Output enables of the three differential pairs |

## Verification
The bench builds the block with `TGT_ADDR` = 7'h3A, so one step in the address, to 7'h3B, is enough to test a non-matching address. It keeps `FILT_LEN` = 3 and `SYNC_STAGES` = 2. With these values, a one-cycle spike on SCL in the low phase, or on SDA in the high phase, is shorter than the filter window, and the byte must still arrive intact. The quarter-bit time of 12 clocks is longer than the synchronizer plus the filter, so the target's SDA changes always fall inside the SCL low phase.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

    localparam int NREGS      = 2;
    localparam int NSTRAP     = 5;
    localparam int NPAIR      = 3;
    localparam int DRV_BIT    = 6;
    localparam int STRAP_REG  = 0;
    localparam logic [7:0] STRAP_MASK = 8'h1F;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK
    } cbs_state_e;

    // reset value of the stored bits of each register
    function automatic logic [7:0] reg_reset(input int idx);
        unique case (idx)
            0:       return 8'h40;
            1:       return 8'h7F;
            default: return 8'h00;
        endcase
    endfunction

    // bits a bus write may change
    function automatic logic [7:0] reg_wmask(input int idx);
        unique case (idx)
            0:       return 8'h40;
            1:       return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cbs_line_filter.sv
module cbs_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_q;
    logic                   synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
        end
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // a new level is accepted after FILT_LEN consecutive mismatching samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_o  <= 1'b1;
            run_q  <= '0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if (synced != lvl_o) begin
                if (run_q == CW'(FILT_LEN - 1)) begin
                    lvl_o  <= synced;
                    run_q  <= '0;
                    rise_o <= synced;
                    fall_o <= !synced;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

endmodule

// File: rtl/cbs_regfile.sv
module cbs_regfile
    import cbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSTRAP-1:0] strap_fs,
    input  logic              wr_en,
    input  logic [6:0]        wr_off,
    input  logic [7:0]        wr_data,
    input  logic [6:0]        rd_off,
    output logic [7:0]        rd_data,
    output logic              drv_high,
    output logic [NPAIR-1:0]  pair_en
);
    logic [7:0]        regs [NREGS];
    logic [NSTRAP-1:0] strap_q;
    logic              strap_done;

    // straps captured once, on the first clock after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q    <= '0;
            strap_done <= 1'b0;
        end else if (!strap_done) begin
            strap_q    <= strap_fs;
            strap_done <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= reg_reset(i);
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (wr_en && wr_off == 7'(i)) begin
                    regs[i] <= (regs[i] & ~reg_wmask(i)) | (wr_data & reg_wmask(i));
                end
            end
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int i = 0; i < NREGS; i++) begin
            if (rd_off == 7'(i)) begin
                if (i == STRAP_REG) begin
                    rd_data = (regs[i] & ~STRAP_MASK) | {{(8-NSTRAP){1'b0}}, strap_q};
                end else begin
                    rd_data = regs[i];
                end
            end
        end
    end

    assign drv_high = regs[0][DRV_BIT];
    assign pair_en  = regs[1][NPAIR-1:0];

endmodule

// File: rtl/cbs_engine.sv
module cbs_engine
    import cbs_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic [7:0] rd_data,
    output logic [6:0] rd_off,
    output logic       wr_en,
    output logic [6:0] wr_off,
    output logic [7:0] wr_data,
    output logic       sda_oe,
    output cbs_state_e state_o
);
    cbs_state_e state, state_n;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [6:0] off;
    logic       byte_end;
    logic       is_rx;

    assign byte_end = scl_fall && (cnt == 4'd8);
    assign is_rx    = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        if (bus_stop) begin
            state_n = ST_IDLE;
        end else if (bus_start) begin
            state_n = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_n = ST_IDLE;
                ST_ADDR: if (byte_end) begin
                    state_n = (shreg[7:1] == TGT_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    state_n = shreg[0] ? ST_RDATA : ST_CMD;
                end
                ST_CMD: if (byte_end) begin
                    state_n = shreg[7] ? ST_CMD_ACK : ST_IDLE;
                end
                ST_CMD_ACK:   if (scl_fall) state_n = ST_WDATA;
                ST_WDATA:     if (byte_end) state_n = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_n = ST_IDLE;
                ST_RDATA:     if (byte_end) state_n = ST_RD_ACK;
                ST_RD_ACK:    if (scl_rise) state_n = ST_IDLE;
                default:      state_n = ST_IDLE;
            endcase
        end
    end

    // bit counter, shift register and latched offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            shreg <= '0;
            off   <= '0;
        end else begin
            if (bus_start || state_n != state) begin
                cnt <= '0;
            end else if (scl_rise && cnt != 4'd8 && (is_rx || state == ST_RDATA)) begin
                cnt <= cnt + 1'b1;
            end

            if (is_rx && scl_rise && cnt != 4'd8) begin
                shreg <= {shreg[6:0], sda_lvl};
            end else if (state == ST_ADDR_ACK && scl_fall && shreg[0]) begin
                shreg <= rd_data;
            end else if (state == ST_RDATA && scl_fall && cnt != 4'd8) begin
                shreg <= {shreg[6:0], 1'b1};
            end

            if (state == ST_CMD && byte_end && shreg[7]) begin
                off <= shreg[6:0];
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = !shreg[7];
            ST_WDATA: wr_en  = byte_end;
            default: ;
        endcase
    end

    assign wr_off  = off;
    assign wr_data = shreg;
    assign rd_off  = off;
    assign state_o = state;

endmodule

// File: rtl/cfg_byte_slave.sv
module cfg_byte_slave
    import cbs_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [NSTRAP-1:0] strap_fs,
    output logic              drv_high,
    output logic [NPAIR-1:0]  pair_en
);
    logic       scl_lvl, scl_rise, scl_fall;
    logic       sda_lvl, sda_rise, sda_fall;
    logic       bus_start, bus_stop;
    logic       wr_en;
    logic [6:0] wr_off, rd_off;
    logic [7:0] wr_data, rd_data;
    cbs_state_e eng_state;

    cbs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    cbs_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    assign bus_start = sda_fall && scl_lvl;
    assign bus_stop  = sda_rise && scl_lvl;

    cbs_engine #(.TGT_ADDR(TGT_ADDR)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .rd_data(rd_data), .rd_off(rd_off),
        .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .sda_oe(sda_oe), .state_o(eng_state)
    );

    cbs_regfile u_regs (
        .clk(clk), .rst_n(rst_n), .strap_fs(strap_fs),
        .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .rd_off(rd_off), .rd_data(rd_data),
        .drv_high(drv_high), .pair_en(pair_en)
    );

endmodule

// File: rtl/cfg_byte_slave_chk.sv
module cbs_checker
    import cbs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             scl_lvl,
    input logic             drv_high,
    input logic [NPAIR-1:0] pair_en,
    input logic             wr_en,
    input logic [6:0]       wr_off,
    input cbs_state_e       eng_state
);
    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_IDLE) |-> !sda_oe);

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_lvl);

    // R6
    drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(drv_high));

    // R7
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pair_en));

    // R9
    far_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_off >= 7'd2) |=> ($stable(drv_high) && $stable(pair_en)));

endmodule

bind cfg_byte_slave cbs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
    .drv_high(drv_high), .pair_en(pair_en), .wr_en(wr_en),
    .wr_off(wr_off), .eng_state(eng_state)
);

// File: tb/cfg_byte_slave_tb_top.sv
`timescale 1ns/1ps
module cfg_byte_slave_tb_top;

    localparam logic [6:0] ADDR = 7'h3A;
    localparam int Q = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [4:0] strap_fs = 5'b10110;
    logic       sda_oe;
    logic       drv_high;
    logic [2:0] pair_en;
    logic       sda_bus;
    logic       glitch_en = 1'b0;
    logic       done = 1'b0;

    int errors = 0;
    int checks = 0;

    string exp_req[$];
    int    exp_val[$];
    int    obs_val[$];

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    cfg_byte_slave #(.TGT_ADDR(ADDR), .SYNC_STAGES(2), .FILT_LEN(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .strap_fs(strap_fs),
        .drv_high(drv_high), .pair_en(pair_en)
    );

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (obs_val.size() > 0 && exp_val.size() > 0) begin
                automatic string r = exp_req.pop_front();
                automatic int    e = exp_val.pop_front();
                automatic int    o = obs_val.pop_front();
                checks++;
                if (o !== e) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", r, o, e);
                end
            end
        end
    end

    task automatic expect_item(input string r, input int v);
        exp_req.push_back(r);
        exp_val.push_back(v);
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;
        if (glitch_en) begin
            wq(5); scl_m = 1'b1; wq(1); scl_m = 1'b0; wq(Q - 6);
        end else begin
            wq(Q);
        end
        scl_m = 1'b1;
        if (glitch_en && !b) begin
            wq(Q); sda_m = 1'b1; wq(1); sda_m = 1'b0; wq(Q - 1);
        end else begin
            wq(2 * Q);
        end
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_bus;  wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(ack);
    endtask

    task automatic bus_write(input logic [6:0] a, input logic [7:0] cmd,
                             input logic [7:0] d, output logic [2:0] acks);
        bus_start();
        send_byte({a, 1'b0}, acks[2]);
        send_byte(cmd, acks[1]);
        send_byte(d, acks[0]);
        bus_stop();
    endtask

    task automatic bus_read(input logic [6:0] a, input logic [7:0] cmd,
                            output logic [7:0] d, output logic [2:0] acks);
        bus_start();
        send_byte({a, 1'b0}, acks[2]);
        send_byte(cmd, acks[1]);
        bus_start();
        send_byte({a, 1'b1}, acks[0]);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(1'b1);
        bus_stop();
    endtask

    task automatic chk_write(input string r, input logic [6:0] a, input logic [7:0] cmd,
                             input logic [7:0] d, input logic [2:0] exp_acks);
        logic [2:0] acks;
        bus_write(a, cmd, d, acks);
        wq(4);
        expect_item(r, int'(exp_acks));
        obs_val.push_back(int'(acks));
    endtask

    task automatic chk_read(input string r, input logic [7:0] cmd, input logic [7:0] exp_d);
        logic [2:0] acks;
        logic [7:0] d;
        bus_read(ADDR, cmd, d, acks);
        expect_item({r, " acks"}, 0);
        obs_val.push_back(int'(acks));
        expect_item(r, int'(exp_d));
        obs_val.push_back(int'(d));
    endtask

    task automatic chk_pins(input string r, input logic exp_drv, input logic [2:0] exp_en);
        expect_item({r, " drv_high"}, int'(exp_drv));
        obs_val.push_back(int'(drv_high));
        expect_item({r, " pair_en"}, int'(exp_en));
        obs_val.push_back(int'(pair_en));
    endtask

    task automatic chk_release(input string r);
        expect_item(r, 0);
        obs_val.push_back(int'(sda_oe));
    endtask

    task automatic finish_run;
        wq(4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(10);
        // R1 reset state of outputs
        chk_pins("R1 reset", 1'b1, 3'b111);
        chk_release("R11 sda released after reset");
        // R1 R4 R8 reset contents through byte reads
        chk_read("R4 R8 read offset 0 after reset", 8'h80, 8'h56);
        chk_read("R1 R7 read offset 1 after reset", 8'h81, 8'h7F);
        // R8 strap pins change later: no effect
        strap_fs = 5'b01001;
        wq(10);
        chk_read("R8 strap change ignored", 8'h80, 8'h56);
        // R3 R6 write drive strength low
        chk_write("R3 write acks", ADDR, 8'h80, 8'h00, 3'b000);
        chk_pins("R6 drive low", 1'b0, 3'b111);
        chk_read("R6 read back offset 0", 8'h80, 8'h16);
        // R6 R8 reserved and strap bits ignore writes
        chk_write("R3 write acks reserved", ADDR, 8'h80, 8'hBF, 3'b000);
        chk_read("R6 R8 reserved/strap not writable", 8'h80, 8'h16);
        chk_write("R3 write acks drive high", ADDR, 8'h80, 8'h40, 3'b000);
        chk_pins("R6 drive high", 1'b1, 3'b111);
        // R7 pair enables
        chk_write("R7 write acks", ADDR, 8'h81, 8'h05, 3'b000);
        chk_pins("R7 enables 101", 1'b1, 3'b101);
        chk_read("R7 read back offset 1", 8'h81, 8'h7D);
        chk_write("R7 write acks upper", ADDR, 8'h81, 8'hF8, 3'b000);
        chk_pins("R7 enables off", 1'b1, 3'b000);
        chk_read("R7 upper bits fixed", 8'h81, 8'h78);
        // R9 far offset
        chk_write("R9 far write acks", ADDR, 8'h85, 8'hFF, 3'b000);
        chk_pins("R9 far write no effect", 1'b1, 3'b000);
        chk_read("R9 far read zero", 8'h85, 8'h00);
        // R2 wrong address
        chk_write("R2 wrong address nack", 7'h3B, 8'h81, 8'h07, 3'b111);
        chk_pins("R2 wrong address no effect", 1'b1, 3'b000);
        // R5 non-byte command
        chk_write("R5 command bit7 clear nack", ADDR, 8'h01, 8'h07, 3'b011);
        chk_pins("R5 no register change", 1'b1, 3'b000);
        // R10 glitches on SCL and SDA
        glitch_en = 1'b1;
        chk_write("R10 glitch write acks", ADDR, 8'h81, 8'h03, 3'b000);
        glitch_en = 1'b0;
        chk_pins("R10 glitch write lands", 1'b1, 3'b011);
        chk_read("R10 read after glitch", 8'h81, 8'h7B);
        chk_release("R11 sda released at end");
        done = 1'b1;
        finish_run();
    end

endmodule